// File: doc/BRIEF.md
# Framed Shift Register Engine

This block is one serial channel built around a shift register of `DW` bits. A timer outside the block marks each frame with a level (`tmr_en`) and supplies a shift clock. The engine shifts on the chosen edge of that clock. In transmit mode it loads a holding buffer into the shift register and drives the bits out LSB first. It can add a start slot before the data and a stop slot after it. In receive mode it assembles incoming bits and checks the start and stop levels. In the two match modes it compares the most recent half-word of input with a masked pattern held in the buffer.

Serial input comes from the pin or from the neighbouring shifter of a chain. The buffer can be written and read through four permuted views. The status flag can serve as a trigger source for a timer. The error flag reports underrun, overrun and framing faults. Both flags are sticky and cleared by write-one strobes.

Top module: `frame_shifter`

## Requirements
- R1: The buffer is written and read through a view selected by a 2-bit code. 0 is the plain word. 1 reverses all bit positions of the word. 2 reverses the order of the bytes. 3 reverses the bits inside each byte. Each view is its own inverse, so a word written and read through the same view comes back unchanged.
- R2: In transmit mode (mode 2), a load moves a full buffer into the shift register and sets the status flag. Data leaves LSB first on `ser_out`, and each active shift edge advances one bit.
- R3: The start field sets the lead-in of a transmit frame. Code 0 loads at the frame begin (rising `tmr_en`) with no lead-in. Code 2 drives a low slot and code 3 a high slot before the first edge, and both load at the frame begin. Code 1 holds the line high and loads on the first shift edge instead.
- R4: In a transmit frame, the edge that ends the last data bit has two outcomes. With stop code 2 or 3 the line then holds the stop level (low or high) until the frame ends. With stop code 0 the next word is loaded at once and sent without a gap.
- R5: A transmit load while the buffer is empty sets the error flag.
- R6: In receive mode (mode 1), each active edge samples one bit, LSB first. After `DW` data bits the word is copied to the buffer, the buffer is marked full and the status flag sets. A pulse on `buf_rd` marks the buffer consumed. Without a stop bit, reception goes on with the next word.
- R7: In receive mode the error flag sets in three cases: a completed word finds the buffer still full, the start slot differs from the start level, or the stop slot differs from the stop level.
- R8: With `chain_sel` high, serial input is taken from `chain_in` instead of `pin_in`.
- R9: With `clk_pol` low the engine shifts on rising edges of `shift_clk`. With `clk_pol` high it shifts on falling edges. The opposite edge has no effect.
- R10: In continuous match (mode 5), every edge compares the window with the pattern and a hit sets the status flag. The window is the last `DW/2` received bits, oldest in bit 0. The pattern is buffer bits `[DW/2-1:0]`, and a 1 in buffer bits `[DW-1:DW/2]` makes that position don't-care. The shift register is cleared at every frame begin in receive and match modes.
- R11: Match-and-store (mode 4) compares only after every `DW/2` edges counted from the frame begin. A hit sets the status flag and writes the window into buffer bits `[DW/2-1:0]`. A hit while the status flag is still set also sets the error flag.
- R12: The flags stay set until `clr_stat` or `clr_err` is pulsed. While the mode is 0 the error flag is held clear.
- R13: After reset both flags are low, the buffer is zero and `ser_out` is high. `ser_out` is also high whenever the mode is not transmit or no frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 3 | 0 off, 1 receive, 2 transmit, 4 match-and-store, 5 continuous match |
| start_cfg | input | 2 | Start-slot code (R3) |
| stop_cfg | input | 2 | Stop-slot code (R4) |
| chain_sel | input | 1 | 1 selects the chained neighbour as serial input |
| clk_pol | input | 1 | 0 shifts on rising, 1 on falling shift-clock edge |
| shift_clk | input | 1 | Shift clock from the timer |
| tmr_en | input | 1 | Frame window from the timer |
| pin_in | input | 1 | Serial input from the pin |
| chain_in | input | 1 | Serial input from the next shifter |
| buf_wr | input | 1 | Buffer write strobe |
| wr_view | input | 2 | View code for writes |
| wr_data | input | DW | Write data |
| buf_rd | input | 1 | Marks the received word consumed |
| rd_view | input | 2 | View code for reads |
| buf_rd_data | output | DW | Buffer seen through `rd_view` |
| clr_stat | input | 1 | Write-one-to-clear for the status flag |
| clr_err | input | 1 | Write-one-to-clear for the error flag |
| ser_out | output | 1 | Serial transmit line |
| chain_out | output | 1 | Shift register LSB, for the previous shifter |
| stat_flag | output | 1 | Status flag, also a timer trigger source |
| err_flag | output | 1 | Error flag |

## Verification
The bench builds the engine with `DW` = 16, so a word is two bytes and the match window is eight bits. At that width every bit of every frame can be checked one by one. The byte-reversal view has a non-trivial case, and a match-and-store stream can put a hit in the middle of a word, where only the half-word boundaries may count. The match runs use a 48-bit stream with a don't-care mask, and the view sweep goes over twenty words in all four views.

// File: rtl/fs_pkg.sv
// Shared codes for the framed shift engine.
// Assumes: field encodings fixed by the block's configuration interface.
package fs_pkg;

    typedef enum logic [2:0] {
        MD_OFF    = 3'd0,
        MD_RX     = 3'd1,
        MD_TX     = 3'd2,
        MD_MSTORE = 3'd4,
        MD_MCONT  = 3'd5
    } fs_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT,
        PH_START,
        PH_DATA,
        PH_STOP
    } fs_phase_e;

    localparam logic [1:0] VIEW_NORM    = 2'd0;
    localparam logic [1:0] VIEW_BITREV  = 2'd1;
    localparam logic [1:0] VIEW_BYTEREV = 2'd2;
    localparam logic [1:0] VIEW_INBYTE  = 2'd3;

    localparam logic [1:0] START_LATE   = 2'd1;

endpackage

// File: rtl/fs_edge.sv
// Shift-clock edge and frame-window detector.
// Assumes shift_clk and tmr_en are synchronous to clk and change at most
// once per clk cycle; one register stage per input.
module fs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_clk,
    input  logic clk_pol,
    input  logic tmr_en,
    output logic shift_ev,
    output logic frame_go,
    output logic frame_end
);
    logic sclk_q;
    logic en_q;

    // Delay both inputs one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            sclk_q <= shift_clk;
            en_q   <= tmr_en;
        end
    end

    // Pick the active edge and flag the frame boundaries.
    always_comb begin
        shift_ev  = clk_pol ? (sclk_q & ~shift_clk) : (~sclk_q & shift_clk);
        frame_go  = tmr_en & ~en_q;
        frame_end = ~tmr_en & en_q;
    end
endmodule

// File: rtl/fs_view.sv
// Buffer view permutation: plain, full bit reversal, byte order reversal,
// bit reversal inside each byte. Assumes DW is a multiple of 8.
module fs_view #(
    parameter int DW = 32
) (
    input  logic [1:0]    sel,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    import fs_pkg::*;
    localparam int NB = DW / 8;

    logic [DW-1:0] rev_all;
    logic [DW-1:0] rev_bytes;
    logic [DW-1:0] rev_in_byte;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign rev_all[i] = din[DW-1-i];
    end

    for (genvar b = 0; b < NB; b++) begin : g_byte
        for (genvar k = 0; k < 8; k++) begin : g_lane
            assign rev_bytes[8*b+k]   = din[8*(NB-1-b)+k];
            assign rev_in_byte[8*b+k] = din[8*b+7-k];
        end
    end

    // Select the requested view.
    always_comb begin
        case (sel)
            VIEW_BITREV:  dout = rev_all;
            VIEW_BYTEREV: dout = rev_bytes;
            VIEW_INBYTE:  dout = rev_in_byte;
            default:      dout = din;
        endcase
    end
endmodule

// File: rtl/fs_match.sv
// Masked half-word comparator. Window is the upper half of the candidate
// shift value; the pattern is the buffer's lower half, the mask its upper
// half (1 = ignore that position).
module fs_match #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] cand,
    input  logic [DW-1:0] pat_buf,
    output logic          hit
);
    localparam int H = DW / 2;

    // Compare only the positions the mask keeps.
    always_comb begin
        hit = (((cand[DW-1:H] ^ pat_buf[H-1:0]) & ~pat_buf[DW-1:H]) == '0);
    end
endmodule

// File: rtl/frame_shifter.sv
// Framed shift engine: transmit, receive and pattern match on one shift
// register, with optional start/stop slots and a permuted buffer.
// Assumes an outside timer supplies the frame window and shift clock,
// and that all inputs are synchronous to clk.
module frame_shifter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode,
    input  logic [1:0]    start_cfg,
    input  logic [1:0]    stop_cfg,
    input  logic          chain_sel,
    input  logic          clk_pol,
    input  logic          shift_clk,
    input  logic          tmr_en,
    input  logic          pin_in,
    input  logic          chain_in,
    input  logic          buf_wr,
    input  logic [1:0]    wr_view,
    input  logic [DW-1:0] wr_data,
    input  logic          buf_rd,
    input  logic [1:0]    rd_view,
    output logic [DW-1:0] buf_rd_data,
    input  logic          clr_stat,
    input  logic          clr_err,
    output logic          ser_out,
    output logic          chain_out,
    output logic          stat_flag,
    output logic          err_flag
);
    import fs_pkg::*;

    localparam int H  = DW / 2;
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] CNT_LAST  = CW'(DW - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(H - 1);

    logic          shift_ev, frame_go, frame_end;
    logic [DW-1:0] wr_norm;
    logic [DW-1:0] sr, sr_n, sr_in;
    logic [DW-1:0] buf_q, buf_n;
    logic          buf_full, full_n;
    logic [CW-1:0] cnt, cnt_n;
    fs_phase_e     phase, phase_n;
    logic          set_stat, set_err, do_load, do_xfer;
    logic          in_bit, hit;
    logic          is_tx, is_rx, is_mcont, is_mstore, active;
    logic          start_on, stop_on;

    fs_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_clk (shift_clk),
        .clk_pol   (clk_pol),
        .tmr_en    (tmr_en),
        .shift_ev  (shift_ev),
        .frame_go  (frame_go),
        .frame_end (frame_end)
    );

    fs_view #(.DW(DW)) u_wr_view (
        .sel  (wr_view),
        .din  (wr_data),
        .dout (wr_norm)
    );

    fs_view #(.DW(DW)) u_rd_view (
        .sel  (rd_view),
        .din  (buf_q),
        .dout (buf_rd_data)
    );

    fs_match #(.DW(DW)) u_match (
        .cand    (sr_in),
        .pat_buf (buf_q),
        .hit     (hit)
    );

    // Decode the mode and framing fields.
    always_comb begin
        is_tx     = (mode == MD_TX);
        is_rx     = (mode == MD_RX);
        is_mcont  = (mode == MD_MCONT);
        is_mstore = (mode == MD_MSTORE);
        active    = is_tx | is_rx | is_mcont | is_mstore;
        start_on  = start_cfg[1];
        stop_on   = stop_cfg[1];
        in_bit    = chain_sel ? chain_in : pin_in;
        sr_in     = {in_bit, sr[DW-1:1]};
    end

    // Frame sequencing, shifting, buffer hand-over and flag events.
    always_comb begin
        phase_n  = phase;
        sr_n     = sr;
        cnt_n    = cnt;
        buf_n    = buf_q;
        full_n   = buf_full;
        set_stat = 1'b0;
        set_err  = 1'b0;
        do_load  = 1'b0;
        do_xfer  = 1'b0;
        if (buf_rd) full_n = 1'b0;
        if (buf_wr) begin
            buf_n  = wr_norm;
            full_n = 1'b1;
        end
        if (!active) begin
            phase_n = PH_IDLE;
            cnt_n   = '0;
        end else if (frame_end) begin
            phase_n = PH_IDLE;
        end else if (frame_go) begin
            cnt_n = '0;
            if (is_tx) begin
                if (start_cfg == START_LATE) begin
                    phase_n = PH_WAIT;
                end else begin
                    do_load = 1'b1;
                    phase_n = start_on ? PH_START : PH_DATA;
                end
            end else begin
                sr_n    = '0;
                phase_n = (is_rx && start_on) ? PH_START : PH_DATA;
            end
        end else if (shift_ev) begin
            case (phase)
                PH_WAIT: begin
                    do_load = 1'b1;
                    phase_n = PH_DATA;
                end
                PH_START: begin
                    if (is_rx && (in_bit != start_cfg[0])) set_err = 1'b1;
                    phase_n = PH_DATA;
                end
                PH_DATA: begin
                    if (is_tx) begin
                        sr_n  = {1'b0, sr[DW-1:1]};
                        cnt_n = cnt + 1'b1;
                        if (cnt == CNT_LAST) begin
                            cnt_n = '0;
                            if (stop_on) phase_n = PH_STOP;
                            else         do_load = 1'b1;
                        end
                    end else if (is_rx) begin
                        sr_n  = sr_in;
                        cnt_n = cnt + 1'b1;
                        if (cnt == CNT_LAST) begin
                            cnt_n   = '0;
                            do_xfer = 1'b1;
                            if (stop_on) phase_n = PH_STOP;
                        end
                    end else if (is_mcont) begin
                        sr_n = sr_in;
                        if (hit) set_stat = 1'b1;
                    end else begin
                        sr_n  = sr_in;
                        cnt_n = cnt + 1'b1;
                        if (cnt == HALF_LAST) begin
                            cnt_n = '0;
                            if (hit) begin
                                if (stat_flag) set_err = 1'b1;
                                set_stat       = 1'b1;
                                buf_n[H-1:0]   = sr_in[DW-1:H];
                            end
                        end
                    end
                end
                PH_STOP: begin
                    if (is_rx) begin
                        if (in_bit != stop_cfg[0]) set_err = 1'b1;
                        phase_n = PH_IDLE;
                    end
                end
                default: begin
                    phase_n = phase;
                end
            endcase
        end
        if (do_load) begin
            if (full_n) begin
                sr_n     = buf_q;
                full_n   = 1'b0;
                set_stat = 1'b1;
            end else begin
                set_err = 1'b1;
            end
        end
        if (do_xfer) begin
            if (full_n) set_err = 1'b1;
            buf_n    = sr_in;
            full_n   = 1'b1;
            set_stat = 1'b1;
        end
    end

    // State registers and sticky flags with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            sr        <= '0;
            cnt       <= '0;
            buf_q     <= '0;
            buf_full  <= 1'b0;
            stat_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            phase     <= phase_n;
            sr        <= sr_n;
            cnt       <= cnt_n;
            buf_q     <= buf_n;
            buf_full  <= full_n;
            stat_flag <= set_stat | (stat_flag & ~clr_stat);
            err_flag  <= active & (set_err | (err_flag & ~clr_err));
        end
    end

    // Serial line: idle high outside a transmit frame.
    always_comb begin
        ser_out = 1'b1;
        if (is_tx) begin
            case (phase)
                PH_START: ser_out = start_cfg[0];
                PH_DATA:  ser_out = sr[0];
                PH_STOP:  ser_out = stop_cfg[0];
                default:  ser_out = 1'b1;
            endcase
        end
        chain_out = sr[0];
    end
endmodule

// File: rtl/fs_checker.sv
// Property checker for frame_shifter, bound into every instance.
module fs_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    mode,
    input logic          buf_wr,
    input logic [1:0]    wr_view,
    input logic [DW-1:0] wr_data,
    input logic [1:0]    rd_view,
    input logic [DW-1:0] buf_rd_data,
    input logic          clr_stat,
    input logic          ser_out,
    input logic          stat_flag,
    input logic          err_flag,
    input logic          shift_ev,
    input logic          frame_go
);
    p_view_rt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && mode == 3'd0) |=>
            ((rd_view != $past(wr_view)) || (buf_rd_data == $past(wr_data))));

    p_stat_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_flag) |-> ($past(mode) != 3'd0));

    p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(shift_ev || frame_go));

    p_err_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |=> !err_flag);

    p_stat_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_flag && !clr_stat) |=> stat_flag);

    p_idle_line_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd2) |-> ser_out);
endmodule

bind frame_shifter fs_checker #(.DW(DW)) u_fs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .buf_wr      (buf_wr),
    .wr_view     (wr_view),
    .wr_data     (wr_data),
    .rd_view     (rd_view),
    .buf_rd_data (buf_rd_data),
    .clr_stat    (clr_stat),
    .ser_out     (ser_out),
    .stat_flag   (stat_flag),
    .err_flag    (err_flag),
    .shift_ev    (shift_ev),
    .frame_go    (frame_go)
);

// File: tb/sim_frame_shifter.sv
module sim_frame_shifter;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic [1:0]    start_cfg = 2'd0, stop_cfg = 2'd0;
    logic          chain_sel = 1'b0, clk_pol = 1'b0, shift_clk = 1'b0, tmr_en = 1'b0;
    logic          pin_in = 1'b0, chain_in = 1'b0;
    logic          buf_wr = 1'b0, buf_rd = 1'b0, clr_stat = 1'b0, clr_err = 1'b0;
    logic [1:0]    wr_view = 2'd0, rd_view = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] buf_rd_data;
    logic          ser_out, chain_out, stat_flag, err_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    frame_shifter #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .start_cfg(start_cfg),
        .stop_cfg(stop_cfg), .chain_sel(chain_sel), .clk_pol(clk_pol),
        .shift_clk(shift_clk), .tmr_en(tmr_en), .pin_in(pin_in),
        .chain_in(chain_in), .buf_wr(buf_wr), .wr_view(wr_view),
        .wr_data(wr_data), .buf_rd(buf_rd), .rd_view(rd_view),
        .buf_rd_data(buf_rd_data), .clr_stat(clr_stat), .clr_err(clr_err),
        .ser_out(ser_out), .chain_out(chain_out), .stat_flag(stat_flag),
        .err_flag(err_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] vref(input logic [15:0] v, input int w);
        logic [15:0] r;
        r = v;
        if (w == 1) for (int i = 0; i < 16; i++) r[i] = v[15-i];
        if (w == 2) r = {v[7:0], v[15:8]};
        if (w == 3) for (int b = 0; b < 2; b++) for (int k = 0; k < 8; k++) r[8*b+k] = v[8*b+7-k];
        return r;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic half(input bit act);
        shift_clk = act ? ~clk_pol : clk_pol;
        tick(2);
    endtask
    task automatic pulse();
        half(1'b1);
        half(1'b0);
    endtask
    task automatic send(input bit b);
        if (chain_sel) chain_in = b; else pin_in = b;
        tick(1);
        pulse();
    endtask
    task automatic wr(input logic [15:0] v, input logic [1:0] w);
        buf_wr = 1'b1; wr_data = v; wr_view = w;
        tick(1);
        buf_wr = 1'b0;
    endtask
    task automatic rd_done();
        buf_rd = 1'b1; tick(1); buf_rd = 1'b0;
    endtask
    task automatic clear_flags();
        clr_stat = 1'b1; clr_err = 1'b1; tick(1);
        clr_stat = 1'b0; clr_err = 1'b0;
    endtask
    task automatic setup(input logic [2:0] md, input logic [1:0] st, input logic [1:0] sp, input bit pol);
        mode = md; start_cfg = st; stop_cfg = sp; clk_pol = pol; shift_clk = pol;
        tick(2);
    endtask
    task automatic go();
        tmr_en = 1'b1; tick(2);
    endtask
    task automatic halt();
        tmr_en = 1'b0; tick(2);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R13 watchdog actual=timeout expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] a, b, b2, c, d, e, f, g, s;
        logic [47:0] strm;
        logic [7:0]  win;
        a = 16'hB4E1; b = 16'h6C39; b2 = 16'h92A7; c = 16'h5A3E;
        d = 16'hC5A3; e = 16'h0F1E; f = 16'h7E81; g = 16'h1248;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R13 reset state
        chk("R13 ser_out", ser_out, 1);
        chk("R13 stat", stat_flag, 0);
        chk("R13 err", err_flag, 0);
        chk("R13 buffer", buf_rd_data, 0);

        // R1 view sweep
        for (int i = 0; i < 20; i++) begin
            logic [15:0] v;
            v = 16'(i * 16'h2F1B + 16'h0703);
            for (int w = 0; w < 4; w++) begin
                wr(v, 2'(w));
                rd_view = 2'd0; #1;
                chk("R1 plain read of viewed write", buf_rd_data, vref(v, w));
                rd_view = 2'(w); #1;
                chk("R1 same-view round trip", buf_rd_data, v);
                rd_view = 2'd0;
            end
        end

        // R2 R4 R9: start 0, stop low, rising edges
        setup(3'd2, 2'd0, 2'd2, 1'b0);
        clear_flags();
        wr(a, 2'd0);
        go();
        chk("R2 stat on load", stat_flag, 1);
        chk("R2 bit 0", ser_out, a[0]);
        half(1'b1);
        chk("R9 active rising edge shifts", ser_out, a[1]);
        half(1'b0);
        chk("R9 falling edge ignored", ser_out, a[1]);
        for (int k = 2; k < 16; k++) begin
            pulse();
            chk("R2 data bit", ser_out, a[k]);
        end
        pulse();
        chk("R4 stop low", ser_out, 0);
        pulse();
        chk("R4 stop held", ser_out, 0);
        chk("R5 no error with full buffer", err_flag, 0);
        halt();
        chk("R13 idle after frame", ser_out, 1);

        // R3 R4 R5 R9: start low, no stop, falling edges, back-to-back words
        setup(3'd2, 2'd2, 2'd0, 1'b1);
        clear_flags();
        wr(b, 2'd0);
        go();
        chk("R3 start low", ser_out, 0);
        clear_flags();
        for (int k = 0; k < 16; k++) begin
            pulse();
            chk("R9 falling-edge data bit", ser_out, b[k]);
            if (k == 8) wr(b2, 2'd0);
        end
        pulse();
        chk("R4 next word without gap", ser_out, b2[0]);
        chk("R2 stat on reload", stat_flag, 1);
        chk("R5 no error on full reload", err_flag, 0);
        for (int k = 1; k < 16; k++) begin
            pulse();
            chk("R4 second word bit", ser_out, b2[k]);
        end
        pulse();
        chk("R5 underrun error", err_flag, 1);
        clr_err = 1'b1; tick(1); clr_err = 1'b0;
        chk("R12 error cleared by strobe", err_flag, 0);
        halt();

        // R3: late load
        setup(3'd2, 2'd1, 2'd0, 1'b0);
        clear_flags();
        wr(c, 2'd0);
        go();
        chk("R3 late load line high", ser_out, 1);
        chk("R3 late load not loaded yet", stat_flag, 0);
        pulse();
        chk("R3 loaded on first edge", stat_flag, 1);
        chk("R3 first data after late load", ser_out, c[0]);
        pulse();
        chk("R3 second data after late load", ser_out, c[1]);
        halt();

        // R3: start high
        setup(3'd2, 2'd3, 2'd0, 1'b0);
        wr(16'h0002, 2'd0);
        go();
        chk("R3 start high", ser_out, 1);
        pulse();
        chk("R3 data after start high", ser_out, 0);
        pulse();
        chk("R3 data bit 1", ser_out, 1);
        halt();

        // R6 R7: receive with start low, stop high
        setup(3'd1, 2'd2, 2'd3, 1'b0);
        clear_flags();
        go();
        send(1'b0);
        for (int k = 0; k < 16; k++) send(d[k]);
        chk("R6 received word", buf_rd_data, d);
        chk("R6 stat on word", stat_flag, 1);
        send(1'b1);
        chk("R7 good frame no error", err_flag, 0);
        halt();

        // R6 R7: overrun then continuous words
        setup(3'd1, 2'd0, 2'd0, 1'b0);
        go();
        for (int k = 0; k < 16; k++) send(e[k]);
        chk("R7 overrun error", err_flag, 1);
        chk("R6 overwritten word", buf_rd_data, e);
        clear_flags();
        rd_done();
        for (int k = 0; k < 16; k++) send(f[k]);
        chk("R6 continuous second word", buf_rd_data, f);
        chk("R6 read strobe prevents overrun", err_flag, 0);
        chk("R6 stat second word", stat_flag, 1);
        halt();
        rd_done();

        // R7: wrong start and stop levels
        setup(3'd1, 2'd2, 2'd2, 1'b0);
        clear_flags();
        go();
        send(1'b1);
        chk("R7 bad start", err_flag, 1);
        clear_flags();
        for (int k = 0; k < 16; k++) send(g[k]);
        chk("R7 no error before stop", err_flag, 0);
        send(1'b1);
        chk("R7 bad stop", err_flag, 1);
        halt();
        rd_done();

        // R8: chained input
        setup(3'd1, 2'd0, 2'd0, 1'b0);
        clear_flags();
        chain_sel = 1'b1;
        pin_in = 1'b1;
        go();
        for (int k = 0; k < 16; k++) send(g[~k[0] ? k : k] ^ 1'b0);
        chk("R8 word from chain input", buf_rd_data, g);
        halt();
        chain_sel = 1'b0;
        rd_done();

        // R10: continuous match, falling edges
        setup(3'd5, 2'd0, 2'd0, 1'b1);
        wr(16'h0FA5, 2'd0);
        clear_flags();
        go();
        strm = 48'h5A_3C_A5_F0_AA_96;
        win = 8'h00;
        for (int i = 0; i < 48; i++) begin
            send(strm[i]);
            win = {strm[i], win[7:1]};
            chk("R10 continuous match", stat_flag, 32'(((win ^ 8'hA5) & ~8'h0F) == 8'h00));
            clr_stat = 1'b1; tick(1); clr_stat = 1'b0;
        end
        halt();

        // R11: match-and-store
        setup(3'd4, 2'd0, 2'd0, 1'b0);
        wr(16'hF00C, 2'd0);
        clear_flags();
        go();
        s = 16'h33C3;
        for (int k = 0; k < 16; k++) send(s[k]);
        chk("R11 no hit off boundary", stat_flag, 0);
        for (int k = 0; k < 8; k++) send(k == 2 || k == 3 || k == 4 || k == 6);
        chk("R11 hit at boundary", stat_flag, 1);
        chk("R11 stored window", buf_rd_data, 16'hF05C);
        chk("R11 first hit no error", err_flag, 0);
        for (int k = 0; k < 8; k++) send(k == 2 || k == 3 || k == 4 || k == 7);
        chk("R11 hit with stat set", err_flag, 1);
        chk("R11 second store", buf_rd_data, 16'hF09C);
        halt();

        // R12: mode 0 clears error, stat stays
        setup(3'd0, 2'd0, 2'd0, 1'b0);
        chk("R12 error cleared when off", err_flag, 0);
        chk("R12 stat sticky", stat_flag, 1);
        clr_stat = 1'b1; tick(1); clr_stat = 1'b0;
        chk("R12 stat cleared by strobe", stat_flag, 0);
        chk("R13 line high when off", ser_out, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule